// File: doc/BRIEF.md
# Instruction-Cycle Time-Base with Skip Flag

This block is a free-running binary counter that advances by one on each instruction cycle. An enable input marks those cycles. The counter is 10 bits wide by default, so it divides the instruction-cycle rate by 1024. For example, a 2.097 MHz oscillator divided by 32 gives an instruction rate of about 65 kHz, and the wrap events then arrive at 64 Hz.

Each wrap sets a sticky overflow flag. Software polls the flag with a test strobe. If the flag is set, the block answers in the same cycle with a skip indication and clears the flag at the next edge. If the flag is clear, the test gives no skip and changes nothing. The overflow is never signalled as an interrupt: it waits until a test collects it. The counter value is also brought out for observation.

Top module: `isc_timebase`

## Requirements
- R1: While `rst_ni` is low, `count_o` is 0 and the overflow flag is clear. The first test after reset therefore gives `skip_o` = 0.
- R2: On each rising edge with `cyc_en_i` high, `count_o` increases by one, modulo 2^CNT_W. With the default width, 1023 is followed by 0.
- R3: On an edge with `cyc_en_i` low, `count_o` keeps its value.
- R4: An edge with `cyc_en_i` high while `count_o` equals 2^CNT_W-1 sets the overflow flag.
- R5: Once set, the flag stays set across any number of cycles without a test, whatever `cyc_en_i` does.
- R6: A test (`test_i` high) while the flag is clear gives `skip_o` = 0, and the flag stays clear.
- R7: A test while the flag is set drives `skip_o` = 1 in that same cycle and clears the flag at the next edge, unless R8 applies.
- R8: If a wrap (R4) falls on the same edge as a test that finds the flag set, the flag stays set, so the new overflow is not lost.
- R9: `skip_o` is never high while `test_i` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cyc_en_i | input | 1 | Instruction-cycle enable; the counter advances when it is high |
| test_i | input | 1 | Test strobe that samples the overflow flag |
| skip_o | output | 1 | High when a test finds the flag set |
| count_o | output | CNT_W | Current counter value, for observation |

## Verification
The counter wrap and the test-and-clear of the flag can fall on the same edge. The bench provokes this on purpose. It first leaves one overflow uncollected, then counts up to the top value and raises `test_i` in the wrap cycle. It then checks that this test skips and that a second test afterwards still skips, before a third test returns no skip. Random runs with a sparse test strobe and a mostly-high enable add more such collisions, and a bench model judges every cycle.

// File: rtl/isc_timebase_pkg.sv
package isc_timebase_pkg;
  parameter int unsigned DEF_CNT_W = 10;

  function automatic logic at_top(input logic [31:0] v, input int unsigned w);
    return v == ((32'd1 << w) - 32'd1);
  endfunction
endpackage

// File: rtl/isc_tb_counter.sv
module isc_tb_counter #(
  parameter int unsigned W = isc_timebase_pkg::DEF_CNT_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] count_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (step_i)  cnt_q <= cnt_q + 1'b1;
  end

  assign wrap_o  = step_i && (cnt_q == TOP);
  assign count_o = cnt_q;
endmodule

// File: rtl/isc_tb_flag.sv
module isc_tb_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic test_i,
  output logic flag_o,
  output logic skip_o
);
  logic flag_q;

  // set wins over the clearing test so a coincident wrap survives
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= set_i | (flag_q & ~test_i);
  end

  assign flag_o = flag_q;
  assign skip_o = test_i & flag_q;
endmodule

// File: rtl/isc_timebase.sv
module isc_timebase #(
  parameter int unsigned CNT_W = isc_timebase_pkg::DEF_CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cyc_en_i,
  input  logic             test_i,
  output logic             skip_o,
  output logic [CNT_W-1:0] count_o
);
  logic wrap;
  logic ovf_flag;

  isc_tb_counter #(.W(CNT_W)) u_cnt (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (cyc_en_i),
    .count_o (count_o),
    .wrap_o  (wrap)
  );

  isc_tb_flag u_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap),
    .test_i (test_i),
    .flag_o (ovf_flag),
    .skip_o (skip_o)
  );
endmodule

// File: rtl/isc_timebase_chk.sv
module isc_timebase_chk #(
  parameter int unsigned W = isc_timebase_pkg::DEF_CNT_W
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         cyc_en_i,
  input logic         test_i,
  input logic         skip_i,
  input logic         flag_i,
  input logic [W-1:0] count_i
);
  localparam logic [W-1:0] TOP = '1;
  logic at_wrap;
  assign at_wrap = cyc_en_i && (count_i == TOP);

  AST_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cyc_en_i |=> count_i == W'($past(count_i) + 1'b1)); // R2
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cyc_en_i |=> $stable(count_i)); // R3
  AST_WRAP_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    at_wrap |=> flag_i); // R4
  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && !test_i) |=> flag_i); // R5
  AST_CLEAR_STAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!flag_i && !at_wrap) |=> !flag_i); // R6
  AST_TEST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && flag_i && !at_wrap) |=> !flag_i); // R7
  AST_COLLIDE_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (test_i && flag_i && at_wrap) |=> flag_i); // R8
  AST_NO_SKIP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !test_i |-> !skip_i); // R9
endmodule

bind isc_timebase isc_timebase_chk #(.W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .cyc_en_i (cyc_en_i),
  .test_i   (test_i),
  .skip_i   (skip_o),
  .flag_i   (ovf_flag),
  .count_i  (count_o)
);

// File: tb/sim_isc_timebase.sv
module sim_isc_timebase;
  localparam int CLK_PERIOD = 10;
  localparam int W = 10;
  localparam int MODV = 1 << W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cyc_en_i = 1'b0;
  logic test_i = 1'b0;
  logic skip_o;
  logic [W-1:0] count_o;

  int total = 0;
  int bad = 0;
  int m_cnt = 0;
  bit m_flag = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  isc_timebase #(.CNT_W(W)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cyc_en_i(cyc_en_i),
    .test_i(test_i), .skip_o(skip_o), .count_o(count_o)
  );

  function automatic bit f_skip(bit t, bit f);
    return t & f;
  endfunction

  function automatic bit f_flag(bit f, bit t, bit en, int c);
    return (en && c == MODV - 1) | (f & ~t);
  endfunction

  function automatic int f_cnt(bit en, int c);
    return en ? (c + 1) % MODV : c;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // called just after a negedge: drive, compare, take the edge, update model
  task automatic step(input bit en, input bit t, input string req);
    cyc_en_i = en;
    test_i = t;
    #1;
    chk({req, " skip"}, int'(skip_o), int'(f_skip(t, m_flag)));
    chk({req, " count"}, int'(count_o), m_cnt);
    if (!t) chk("R9 skip w/o test", int'(skip_o), 0);
    @(posedge clk);
    m_flag = f_flag(m_flag, t, en, m_cnt);
    m_cnt = f_cnt(en, m_cnt);
    @(negedge clk);
  endtask

  task automatic run_to_top();
    int i = 0;
    while (m_cnt != MODV - 1) begin
      step((i % 7) != 3, 1'b0, "R2R3 count");
      i++;
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    rst_ni = 1'b0;
    test_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset count", int'(count_o), 0);
    chk("R1 reset skip", int'(skip_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, "R1R6 first test");
    step(1'b0, 1'b1, "R6 repeat test");
    step(1'b0, 1'b0, "R3 idle hold");
    run_to_top();
    step(1'b1, 1'b0, "R4 wrap");
    repeat (5) step(1'b0, 1'b0, "R5 hold no en");
    repeat (5) step(1'b1, 1'b0, "R5 hold en");
    run_to_top();
    step(1'b1, 1'b1, "R8 collide");
    step(1'b1, 1'b1, "R8 kept");
    step(1'b1, 1'b1, "R7 cleared");
    run_to_top();
    step(1'b1, 1'b0, "R4 wrap2");
    step(1'b0, 1'b1, "R7 test set");
    step(1'b0, 1'b1, "R7 after clear");
    run_to_top();
    step(1'b1, 1'b1, "R6 wrap with clear flag");
    step(1'b0, 1'b1, "R4 flag from wrap");
    for (int k = 0; k < 6000; k++) begin
      bit en = ($urandom % 8) != 0;
      bit t  = ($urandom % 64) == 0;
      step(en, t, "R2R7 random");
    end
    run_to_top();
    step(1'b1, 1'b0, "R4 wrap3");
    step(1'b0, 1'b0, "R5 pre reset");
    rst_ni = 1'b0;
    #1;
    chk("R1 async reset count", int'(count_o), 0);
    m_cnt = 0;
    m_flag = 1'b0;
    @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    step(1'b0, 1'b1, "R1 flag cleared");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule